// File: doc/BRIEF.md
# Bus Engine Register and Interrupt File

This block holds the software-visible state of one two-wire serial bus engine: a function-control word, two clock-timing words, an interrupt enable mask, an interrupt status word, a one-byte transmit/receive buffer, and a command word that also reports the sequencer state. Software reaches it through a simple single-cycle register port. A separate command sequencer drives it from the other side. The sequencer reports completed bus events as one-cycle pulses, returns received bytes, clears the command bits it has finished and publishes its state code.

Each event pulse sets a sticky status bit. In the same update the whole status word is ANDed with the enable mask, and the interrupt output follows whether any bit survives. Software clears status bits by writing ones to them, and the interrupt line drops once the word reaches zero. When software acknowledges a receive-done while a receive command is still outstanding, the block emits a re-arm pulse so that the sequencer fetches the next byte.

Top module: `i2cb_reg_file`

## Requirements
- R1: Offsets map as 0x00 function control, 0x04 timing A, 0x08 timing B, 0x0C interrupt enable, 0x10 interrupt status, 0x14 command, 0x20 byte buffer. Writes keep only the bits in 0x0071C3FF (control), 0x0FFFFF0F (timing A), 0x7 (timing B) and 0x7FFF (enable). Reads of any other offset return all ones.
- R2: A control write with bit 1 (target-mode enable) set is discarded and leaves the control word unchanged.
- R3: Event pulse bit k sets status bit k (0 address/data acked, 1 not acked, 2 byte received, 3 arbitration lost, 4 stop done, 5 stop refused). In that cycle the status becomes (old status OR events) AND enable, and `irq` is 1 exactly when that result is nonzero.
- R4: Writing the status offset clears each of bits 0 to 14 where the written value has a 1. When such a write leaves the status at zero, `irq` goes to 0. Otherwise `irq` keeps its value.
- R5: A status write with bit 2 set, while status bit 2 is 1 and command bit 3 (receive) or bit 4 (receive-last) is 1, produces a one-cycle `rx_rearm` pulse in the following cycle. Otherwise no pulse is produced.
- R6: A buffer write loads bits 7:0 into the transmit byte and zeroes the received byte. A sequencer `rx_load` places `rx_byte` in bits 15:8 and zeroes bits 7:0.
- R7: A read of the command offset returns the stored command in bits 15:0, `bus_busy` in bit 16, the sequencer state code in bits 22:19, and zero elsewhere.
- R8: A command write stores bits 15:0 and pulses `cmd_go` for one cycle only when control bit 0 (controller enable) is 1. Otherwise the write is ignored.
- R9: `cmd_clr` clears the matching stored command bits. `state_wr` loads `state_val` into the state code.
- R10: Reset clears enable, status, command, state, buffer, `irq`, `cmd_go` and `rx_rearm`. It leaves the control and timing words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| evt_pulse | input | 6 | One-cycle event pulses from the sequencer, bit k = status bit k |
| rx_load | input | 1 | Received byte valid |
| rx_byte | input | 8 | Received byte |
| cmd_clr | input | 16 | Command bits finished by the sequencer |
| state_wr | input | 1 | State code update strobe |
| state_val | input | 4 | New state code |
| bus_busy | input | 1 | Bus busy flag, reported in the command read |
| cfg_ctrl | output | 32 | Function-control word |
| cfg_timing_a | output | 32 | Timing word A |
| cfg_timing_b | output | 32 | Timing word B |
| tx_byte | output | 8 | Byte to transmit |
| cmd_bits | output | 16 | Stored command bits |
| cmd_go | output | 1 | Pulse after an accepted command write |
| rx_rearm | output | 1 | Pulse requesting the next receive |
| irq | output | 1 | Pending interrupt |

## Verification
The re-arm pulse is the hardest case to reach. It needs three conditions at once: a receive command already stored, which in turn needs controller mode enabled; a receive-done bit that survived the enable mask; and a status write that acknowledges that bit. The stimulus builds this up step by step, checks the pulse, and then repeats the write once the status is already clear and once the command bits have been retired, expecting no pulse in either case. Masking is exercised with events whose enable bits are off while other bits are on, so that a correct status word differs from a plain OR of the events.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

    parameter int unsigned DATA_W  = 32;
    parameter int unsigned ADDR_W  = 6;
    parameter int unsigned STS_W   = 15;
    parameter int unsigned EVT_W   = 6;
    parameter int unsigned CMD_W   = 16;
    parameter int unsigned STATE_W = 4;
    parameter int unsigned BYTE_W  = 8;

    // register offsets
    localparam logic [ADDR_W-1:0] OFS_CTRL = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_TMA  = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_TMB  = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_EN   = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_STS  = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_CMD  = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_BUF  = 6'h20;

    // writable-bit masks
    localparam logic [DATA_W-1:0] MASK_CTRL = 32'h0071_C3FF;
    localparam logic [DATA_W-1:0] MASK_TMA  = 32'h0FFF_FF0F;
    localparam logic [DATA_W-1:0] MASK_TMB  = 32'h0000_0007;

    // field positions
    localparam int unsigned CTRL_HOST_EN = 0;
    localparam int unsigned CTRL_TGT_EN  = 1;
    localparam int unsigned CMD_RECV     = 3;
    localparam int unsigned CMD_RECV_END = 4;
    localparam int unsigned BUSY_POS     = 16;
    localparam int unsigned STATE_LSB    = 19;
    localparam int unsigned RXB_LSB      = BYTE_W;

    typedef enum logic [2:0] {
        EV_ACK   = 3'd0,
        EV_NAK   = 3'd1,
        EV_RXD   = 3'd2,
        EV_ARB   = 3'd3,
        EV_STOP  = 3'd4,
        EV_ABORT = 3'd5
    } evt_idx_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } reg_req_t;

    typedef struct packed {
        logic [BYTE_W-1:0] rx;
        logic [BYTE_W-1:0] tx;
    } byte_buf_t;

    function automatic logic wr_hit(reg_req_t r, logic [ADDR_W-1:0] ofs);
        return r.wr && (r.addr == ofs);
    endfunction

    function automatic logic [DATA_W-1:0] cmd_view(logic [CMD_W-1:0] c,
                                                   logic busy,
                                                   logic [STATE_W-1:0] st);
        logic [DATA_W-1:0] v;
        v = '0;
        v[CMD_W-1:0] = c;
        v[BUSY_POS] = busy;
        v[STATE_LSB +: STATE_W] = st;
        return v;
    endfunction

endpackage

// File: rtl/i2cb_cfg_regs.sv
module i2cb_cfg_regs
    import i2cb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic              wr_tma,
    input  logic              wr_tmb,
    input  logic              wr_buf,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rx_load,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic [DATA_W-1:0] ctrl,
    output logic [DATA_W-1:0] tma,
    output logic [DATA_W-1:0] tmb,
    output byte_buf_t         bbuf
);
    localparam int unsigned NUM_TM = 2;

    logic [DATA_W-1:0] ctrl_q = '0;
    logic [DATA_W-1:0] tm_q [NUM_TM];
    logic              tm_we [NUM_TM];
    byte_buf_t         buf_q;

    assign tm_we[0] = wr_tma;
    assign tm_we[1] = wr_tmb;

    // control word survives reset; target-mode requests are refused
    always_ff @(posedge clk) begin
        if (wr_ctrl && !wdata[CTRL_TGT_EN])
            ctrl_q <= wdata & MASK_CTRL;
    end

    for (genvar g = 0; g < NUM_TM; g++) begin : g_tm
        localparam logic [DATA_W-1:0] MSK = (g == 0) ? MASK_TMA : MASK_TMB;
        initial tm_q[g] = '0;
        always_ff @(posedge clk) begin
            if (tm_we[g])
                tm_q[g] <= wdata & MSK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            buf_q <= '0;
        else if (wr_buf)
            buf_q <= '{rx: '0, tx: wdata[BYTE_W-1:0]};
        else if (rx_load)
            buf_q <= '{rx: rx_byte, tx: '0};
    end

    assign ctrl = ctrl_q;
    assign tma  = tm_q[0];
    assign tmb  = tm_q[1];
    assign bbuf = buf_q;

    p_tgt_refused_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && wdata[CTRL_TGT_EN]) |=> $stable(ctrl));

    p_rx_load_r6: assert property (@(posedge clk) disable iff (rst)
        (rx_load && !wr_buf) |=> (bbuf.rx == $past(rx_byte) && bbuf.tx == '0));

endmodule

// File: rtl/i2cb_cmd_word.sv
module i2cb_cmd_word
    import i2cb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_cmd,
    input  logic [CMD_W-1:0]   wdata,
    input  logic               host_en,
    input  logic [CMD_W-1:0]   cmd_clr,
    input  logic               state_wr,
    input  logic [STATE_W-1:0] state_val,
    output logic [CMD_W-1:0]   cmd,
    output logic [STATE_W-1:0] state,
    output logic               go
);
    logic [CMD_W-1:0]   cmd_q;
    logic [STATE_W-1:0] state_q;
    logic               go_q;
    logic               accept;

    assign accept = wr_cmd && host_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            go_q  <= 1'b0;
        end else begin
            go_q <= accept;
            if (accept)
                cmd_q <= wdata;
            else
                cmd_q <= cmd_q & ~cmd_clr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= '0;
        else if (state_wr)
            state_q <= state_val;
    end

    assign cmd   = cmd_q;
    assign state = state_q;
    assign go    = go_q;

    p_go_needs_host_r8: assert property (@(posedge clk) disable iff (rst)
        go |-> $past(wr_cmd && host_en));

    p_locked_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_cmd && !host_en && cmd_clr == '0) |=> $stable(cmd));

    p_clr_r9: assert property (@(posedge clk) disable iff (rst)
        (!wr_cmd) |=> ((cmd & $past(cmd_clr)) == '0));

endmodule

// File: rtl/i2cb_intr_unit.sv
module i2cb_intr_unit
    import i2cb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sts,
    input  logic [STS_W-1:0] wdata,
    input  logic [EVT_W-1:0] evt,
    input  logic             rx_pending,
    output logic [STS_W-1:0] en,
    output logic [STS_W-1:0] status,
    output logic             irq,
    output logic             rearm
);
    logic [STS_W-1:0] en_q, sts_q, sts_n, clr, after_clr, set_v;
    logic             irq_q, irq_n, rearm_n, evt_any;

    assign evt_any   = |evt;
    assign clr       = wr_sts ? wdata : '0;
    assign after_clr = sts_q & ~clr;
    assign set_v     = STS_W'(evt);

    always_comb begin
        sts_n = after_clr | set_v;
        if (evt_any)
            sts_n = sts_n & en_q;
    end

    always_comb begin
        if (evt_any)
            irq_n = |sts_n;
        else if (wr_sts && sts_n == '0)
            irq_n = 1'b0;
        else
            irq_n = irq_q;
    end

    assign rearm_n = wr_sts && wdata[EV_RXD] && sts_q[EV_RXD] && rx_pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            sts_q   <= '0;
            irq_q   <= 1'b0;
            rearm   <= 1'b0;
        end else begin
            if (wr_en)
                en_q <= wdata;
            sts_q <= sts_n;
            irq_q <= irq_n;
            rearm <= rearm_n;
        end
    end

    assign en     = en_q;
    assign status = sts_q;
    assign irq    = irq_q;

    p_irq_cause_r3: assert property (@(posedge clk) disable iff (rst)
        irq |-> (status != '0));

    p_masked_r3: assert property (@(posedge clk) disable iff (rst)
        evt_any |=> ((status & ~$past(en)) == '0));

    p_w1c_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_sts && !evt_any) |=> ((status & $past(wdata)) == '0));

    p_rearm_r5: assert property (@(posedge clk) disable iff (rst)
        rearm |-> $past(wr_sts && wdata[EV_RXD] && rx_pending));

endmodule

// File: rtl/i2cb_reg_file.sv
module i2cb_reg_file
    import i2cb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [EVT_W-1:0]   evt_pulse,
    input  logic               rx_load,
    input  logic [BYTE_W-1:0]  rx_byte,
    input  logic [CMD_W-1:0]   cmd_clr,
    input  logic               state_wr,
    input  logic [STATE_W-1:0] state_val,
    input  logic               bus_busy,
    output logic [DATA_W-1:0]  cfg_ctrl,
    output logic [DATA_W-1:0]  cfg_timing_a,
    output logic [DATA_W-1:0]  cfg_timing_b,
    output logic [BYTE_W-1:0]  tx_byte,
    output logic [CMD_W-1:0]   cmd_bits,
    output logic               cmd_go,
    output logic               rx_rearm,
    output logic               irq
);
    reg_req_t           req;
    byte_buf_t          bbuf;
    logic [STS_W-1:0]   en_w, sts_w;
    logic [STATE_W-1:0] state_w;
    logic               rx_pending;

    assign req = '{wr: reg_wr, addr: reg_addr, data: reg_wdata};

    i2cb_cfg_regs u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_ctrl (wr_hit(req, OFS_CTRL)),
        .wr_tma  (wr_hit(req, OFS_TMA)),
        .wr_tmb  (wr_hit(req, OFS_TMB)),
        .wr_buf  (wr_hit(req, OFS_BUF)),
        .wdata   (req.data),
        .rx_load (rx_load),
        .rx_byte (rx_byte),
        .ctrl    (cfg_ctrl),
        .tma     (cfg_timing_a),
        .tmb     (cfg_timing_b),
        .bbuf    (bbuf)
    );

    i2cb_cmd_word u_cmd (
        .clk       (clk),
        .rst       (rst),
        .wr_cmd    (wr_hit(req, OFS_CMD)),
        .wdata     (req.data[CMD_W-1:0]),
        .host_en   (cfg_ctrl[CTRL_HOST_EN]),
        .cmd_clr   (cmd_clr),
        .state_wr  (state_wr),
        .state_val (state_val),
        .cmd       (cmd_bits),
        .state     (state_w),
        .go        (cmd_go)
    );

    assign rx_pending = cmd_bits[CMD_RECV] | cmd_bits[CMD_RECV_END];

    i2cb_intr_unit u_intr (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_hit(req, OFS_EN)),
        .wr_sts     (wr_hit(req, OFS_STS)),
        .wdata      (req.data[STS_W-1:0]),
        .evt        (evt_pulse),
        .rx_pending (rx_pending),
        .en         (en_w),
        .status     (sts_w),
        .irq        (irq),
        .rearm      (rx_rearm)
    );

    assign tx_byte = bbuf.tx;

    always_comb begin
        unique case (reg_addr)
            OFS_CTRL: reg_rdata = cfg_ctrl;
            OFS_TMA:  reg_rdata = cfg_timing_a;
            OFS_TMB:  reg_rdata = cfg_timing_b;
            OFS_EN:   reg_rdata = DATA_W'(en_w);
            OFS_STS:  reg_rdata = DATA_W'(sts_w);
            OFS_CMD:  reg_rdata = cmd_view(cmd_bits, bus_busy, state_w);
            OFS_BUF:  reg_rdata = DATA_W'(bbuf);
            default:  reg_rdata = '1;
        endcase
    end

    p_reset_r10: assert property (@(posedge clk)
        rst |=> (sts_w == '0 && en_w == '0 && cmd_bits == '0 && !irq));

endmodule

// File: tb/i2cb_reg_file_tb.sv
module i2cb_reg_file_tb;
    import i2cb_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               reg_wr = 1'b0;
    logic [ADDR_W-1:0]  reg_addr = '0;
    logic [DATA_W-1:0]  reg_wdata = '0;
    logic [DATA_W-1:0]  reg_rdata;
    logic [EVT_W-1:0]   evt_pulse = '0;
    logic               rx_load = 1'b0;
    logic [BYTE_W-1:0]  rx_byte = '0;
    logic [CMD_W-1:0]   cmd_clr = '0;
    logic               state_wr = 1'b0;
    logic [STATE_W-1:0] state_val = '0;
    logic               bus_busy = 1'b0;
    logic [DATA_W-1:0]  cfg_ctrl, cfg_timing_a, cfg_timing_b;
    logic [BYTE_W-1:0]  tx_byte;
    logic [CMD_W-1:0]   cmd_bits;
    logic               cmd_go, rx_rearm, irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    i2cb_reg_file u_dut (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse(logic [5:0] e);
        @(negedge clk);
        evt_pulse = e;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    task automatic t_reset_state;
        logic [31:0] v;
        rd(6'h0C, v); check("R10 enable after reset", v, 0);
        rd(6'h10, v); check("R10 status after reset", v, 0);
        rd(6'h14, v); check("R10 command after reset", v, 0);
        rd(6'h20, v); check("R10 buffer after reset", v, 0);
        check("R10 irq after reset", irq, 0);
    endtask

    task automatic t_masks;
        logic [31:0] v;
        wr(6'h00, 32'hFFFF_FFFD); rd(6'h00, v); check("R1 control mask", v, 32'h0071_C3FD);
        wr(6'h04, 32'hFFFF_FFFF); rd(6'h04, v); check("R1 timing A mask", v, 32'h0FFF_FF0F);
        wr(6'h08, 32'hFFFF_FFFF); rd(6'h08, v); check("R1 timing B mask", v, 32'h7);
        wr(6'h0C, 32'hFFFF_FFFF); rd(6'h0C, v); check("R1 enable mask", v, 32'h7FFF);
        rd(6'h18, v); check("R1 unmapped read", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_target_refused;
        logic [31:0] v;
        wr(6'h00, 32'h0000_0003); rd(6'h00, v);
        check("R2 target enable refused", v, 32'h0071_C3FD);
        wr(6'h00, 32'h1); rd(6'h00, v); check("R2 plain write accepted", v, 32'h1);
    endtask

    task automatic t_events;
        logic [31:0] v;
        wr(6'h0C, 32'h7FFF);
        pulse(6'b000001); rd(6'h10, v); check("R3 ack latched", v, 32'h1);
        check("R3 irq raised", irq, 1);
        wr(6'h10, 32'h1); rd(6'h10, v); check("R4 w1c clears", v, 0);
        check("R4 irq drops at zero", irq, 0);
        wr(6'h0C, 32'h4);
        pulse(6'b000110); rd(6'h10, v); check("R3 nak masked off", v, 32'h4);
        check("R3 irq on surviving bit", irq, 1);
        wr(6'h10, 32'h4);
        wr(6'h0C, 32'h1);
        pulse(6'b000010); rd(6'h10, v); check("R3 fully masked", v, 0);
        check("R3 no irq when nothing survives", irq, 0);
        wr(6'h0C, 32'h3F);
        pulse(6'b111111); rd(6'h10, v); check("R3 all six events", v, 32'h3F);
        wr(6'h10, 32'h30); rd(6'h10, v); check("R4 partial clear", v, 32'h0F);
        check("R4 irq held while bits remain", irq, 1);
        wr(6'h10, 32'h7FFF); check("R4 irq after full clear", irq, 0);
    endtask

    task automatic t_rearm;
        logic [31:0] v;
        wr(6'h0C, 32'h7FFF);
        wr(6'h14, 32'h0008);
        check("R8 go after accepted command", cmd_go, 1);
        rd(6'h14, v); check("R8 command stored", v, 32'h8);
        pulse(6'b000100);
        wr(6'h10, 32'h4); check("R5 rearm on rx ack", rx_rearm, 1);
        @(negedge clk); check("R5 rearm single cycle", rx_rearm, 0);
        wr(6'h10, 32'h4); check("R5 no rearm with rx bit clear", rx_rearm, 0);
        @(negedge clk); cmd_clr = 16'h0008; @(negedge clk); cmd_clr = '0;
        rd(6'h14, v); check("R9 command bit retired", v, 0);
        pulse(6'b000100);
        wr(6'h10, 32'h4); check("R5 no rearm without receive", rx_rearm, 0);
        wr(6'h14, 32'h0010); pulse(6'b000100);
        wr(6'h10, 32'h4); check("R5 rearm on receive-last", rx_rearm, 1);
        @(negedge clk); cmd_clr = 16'h0010; @(negedge clk); cmd_clr = '0;
    endtask

    task automatic t_buffer;
        logic [31:0] v;
        wr(6'h20, 32'h0000_1234); rd(6'h20, v); check("R6 tx byte only", v, 32'h34);
        check("R6 tx_byte port", tx_byte, 32'h34);
        @(negedge clk); rx_load = 1'b1; rx_byte = 8'hAB; @(negedge clk); rx_load = 1'b0;
        rd(6'h20, v); check("R6 rx byte high", v, 32'hAB00);
        wr(6'h20, 32'h55); rd(6'h20, v); check("R6 write zeroes rx", v, 32'h55);
    endtask

    task automatic t_cmd_view;
        logic [31:0] v;
        wr(6'h14, 32'hFFFF_0022);
        @(negedge clk); state_wr = 1'b1; state_val = 4'hC; bus_busy = 1'b1;
        @(negedge clk); state_wr = 1'b0;
        rd(6'h14, v); check("R7 command view", v, 32'h0061_0022);
        @(negedge clk); cmd_clr = 16'h0002; @(negedge clk); cmd_clr = '0;
        rd(6'h14, v); check("R9 partial clear and state", v, 32'h0061_0020);
        bus_busy = 1'b0;
    endtask

    task automatic t_cmd_locked;
        logic [31:0] v;
        wr(6'h00, 32'h0);
        wr(6'h14, 32'h0002);
        check("R8 no go when disabled", cmd_go, 0);
        rd(6'h14, v); check("R8 command unchanged", v, 32'h0060_0020);
    endtask

    task automatic t_reset_keep;
        logic [31:0] v;
        wr(6'h00, 32'h1); wr(6'h08, 32'h5); wr(6'h0C, 32'h3F);
        pulse(6'b000001);
        @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
        rd(6'h00, v); check("R10 control kept", v, 32'h1);
        rd(6'h04, v); check("R10 timing A kept", v, 32'h0FFF_FF0F);
        rd(6'h08, v); check("R10 timing B kept", v, 32'h5);
        rd(6'h0C, v); check("R10 enable cleared", v, 0);
        rd(6'h10, v); check("R10 status cleared", v, 0);
        rd(6'h14, v); check("R10 command cleared", v, 32'h0);
        check("R10 irq cleared", irq, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_masks();
        t_target_refused();
        t_events();
        t_rearm();
        t_buffer();
        t_cmd_view();
        t_cmd_locked();
        t_reset_keep();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule